// File: doc/BRIEF.md
# Register Rename Map Unit

This unit sits between decode and the out-of-order back end and renames one instruction per cycle. It holds an alias table that records, for every architectural register, the physical register that currently carries its newest value, plus a first-in first-out pool of physical registers that nothing references. For each offered instruction it translates two source register numbers into physical tags. If the instruction has a destination, it also takes the oldest free tag, reports the tag that the destination pointed to until then, and redirects the table entry to the new tag.

The replaced tag goes downstream with the instruction. Commit later hands it back so it can rejoin the pool. Recovery from a wrong path walks the squashed instructions from youngest to oldest and returns each {destination, replaced tag, allocated tag} record through the undo port. That restores the table entry and returns the allocated tag to the pool, so no snapshot of the table is kept. Decode is held off only when an instruction needs a destination and the pool is empty, or while an undo is being applied.

The physical register count is derived: architectural registers plus reorder-buffer depth, rounded up to a power of two. With the defaults (8 architectural registers, 8 in-flight entries) there are 16 physical registers.

Top module: `rename_map_unit`

## Requirements
- R1: After reset, architectural register i reads as physical tag i. The pool holds tags ARCH_REGS through PHYS_REGS-1, oldest first in ascending order, so with the defaults 8 allocations (tags 8 to 15) succeed before the pool runs dry.
- R2: Source tags are read from the current table, so a source that names the destination of an earlier renamed instruction returns that instruction's allocated tag.
- R3: Sources are read before the same cycle's destination update, so an instruction whose source equals its destination reads the previous tag.
- R4: An accepted instruction with a destination receives the oldest tag in the pool on outNewTag, in first-in first-out order.
- R5: outOldTag shows the tag that the destination mapped to before the instruction. From the next cycle the table entry holds outNewTag.
- R6: renReady is 0 when renHasDst is 1 and the pool is empty. Renaming resumes in the cycle after a commit returns a tag.
- R7: An instruction with renHasDst 0 is accepted even with an empty pool and consumes no tag: the next allocation gets the same tag it would have got without it.
- R8: A commit (cmtValid 1) appends cmtTag at the tail of the pool.
- R9: An undo (undoValid 1) writes undoOldTag into the entry for undoDst and appends undoNewTag to the pool. renReady is 0 in any cycle with undoValid 1.
- R10: A tag returned by commit in a cycle is not handed out in that same cycle. An allocation and a commit in one cycle are both applied.
- R11: A commit and an undo in the same cycle both append, the commit tag ahead of the undo tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| renValid | input | 1 | An instruction is offered for renaming |
| renHasDst | input | 1 | The offered instruction writes a register |
| renSrcA | input | 3 | First source architectural register |
| renSrcB | input | 3 | Second source architectural register |
| renDst | input | 3 | Destination architectural register |
| renReady | output | 1 | Offer is taken this cycle when renValid is 1 |
| outSrcATag | output | 4 | Physical tag of first source |
| outSrcBTag | output | 4 | Physical tag of second source |
| outNewTag | output | 4 | Tag allocated for the destination |
| outOldTag | output | 4 | Tag the destination mapped to before |
| cmtValid | input | 1 | Commit returns a tag |
| cmtTag | input | 4 | Replaced tag of the committing instruction |
| undoValid | input | 1 | Apply one undo record |
| undoDst | input | 3 | Destination of the squashed instruction |
| undoOldTag | input | 4 | Tag to write back into the table |
| undoNewTag | input | 4 | Tag to return to the pool |

## Verification
A corrupted table entry appears at the ports the first time a later instruction names that register as a source or destination, on outSrcATag, outSrcBTag or outOldTag in that same cycle. A wrong pool pointer or count appears on the next allocation, as an out-of-order outNewTag, or as renReady dropping early or staying high when the pool is empty. The tests therefore follow each write, free and undo with a rename that reads the affected entry or takes the affected tag, so a fault is seen within one or two cycles.

// File: rtl/rename_pkg.sv
package rename_pkg;
  // Strobes from control to the datapath, one per state-changing action.
  typedef struct packed {
    logic alloc;   // take head tag and update the destination entry
    logic commit;  // append the commit tag to the pool
    logic undo;    // restore a table entry and append the undone tag
  } rnStrobe_t;
endpackage

// File: rtl/rename_ctrl.sv
module rename_ctrl
  import rename_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       renValid,
  input  logic       renHasDst,
  input  logic       cmtValid,
  input  logic       undoValid,
  input  logic       freeEmpty,
  output logic       renReady,
  output rnStrobe_t  strobe
);
  // Undo has priority over rename; a destination needs a free tag.
  always_comb begin
    renReady      = !undoValid && (!renHasDst || !freeEmpty);
    strobe.alloc  = renValid && renReady && renHasDst;
    strobe.commit = cmtValid;
    strobe.undo   = undoValid;
  end

  // R9: no allocation is issued while an undo record is applied
  assert_undo_blocks_R9: assert property (@(posedge clk) disable iff (!rstN)
    undoValid |-> !strobe.alloc);
endmodule

// File: rtl/rename_freelist.sv
module rename_freelist
  import rename_pkg::*;
#(
  parameter int ARCH_REGS = 8,
  parameter int PHYS_REGS = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  rnStrobe_t                    strobe,
  input  logic [$clog2(PHYS_REGS)-1:0] cmtTag,
  input  logic [$clog2(PHYS_REGS)-1:0] undoTag,
  output logic [$clog2(PHYS_REGS)-1:0] headTag,
  output logic                         empty
);
  localparam int PW = $clog2(PHYS_REGS);
  localparam int CW = $clog2(PHYS_REGS + 1);
  localparam int INIT_FREE = PHYS_REGS - ARCH_REGS;

  logic [PW-1:0] pool [PHYS_REGS];
  logic [PW-1:0] headPtr, tailPtr;
  logic [CW-1:0] freeCnt;
  logic [1:0]    pushN;
  logic [PW-1:0] undoSlot;

  always_comb begin
    pushN    = {1'b0, strobe.commit} + {1'b0, strobe.undo};
    undoSlot = strobe.commit ? tailPtr + PW'(1) : tailPtr;
    headTag  = pool[headPtr];
    empty    = (freeCnt == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < PHYS_REGS; k++)
        pool[k] <= (k < INIT_FREE) ? PW'(ARCH_REGS + k) : '0;
      headPtr <= '0;
      tailPtr <= PW'(INIT_FREE);
      freeCnt <= CW'(INIT_FREE);
    end else begin
      // Writes land at the tail; the head entry read this cycle is untouched
      // unless the pool was empty, in which case no pop happens.
      if (strobe.commit) pool[tailPtr]  <= cmtTag;
      if (strobe.undo)   pool[undoSlot] <= undoTag;
      tailPtr <= tailPtr + PW'(pushN);
      if (strobe.alloc) headPtr <= headPtr + PW'(1);
      freeCnt <= freeCnt + CW'(pushN) - CW'(strobe.alloc);
    end
  end

  // R6: never pop an empty pool
  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.alloc |-> !empty);
  // R8: the pool never holds more tags than exist
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rstN)
    freeCnt <= CW'(PHYS_REGS));
  // R10: a cycle that starts empty cannot hand out a tag freed in it
  assert_no_same_cycle_reuse_R10: assert property (@(posedge clk) disable iff (!rstN)
    (empty && strobe.commit) |=> (freeCnt == CW'(1) + CW'($past(strobe.undo))));
endmodule

// File: rtl/rename_table.sv
module rename_table
  import rename_pkg::*;
#(
  parameter int ARCH_REGS = 8,
  parameter int PHYS_REGS = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  rnStrobe_t                    strobe,
  input  logic [$clog2(ARCH_REGS)-1:0] srcA,
  input  logic [$clog2(ARCH_REGS)-1:0] srcB,
  input  logic [$clog2(ARCH_REGS)-1:0] dst,
  input  logic [$clog2(PHYS_REGS)-1:0] newTag,
  input  logic [$clog2(ARCH_REGS)-1:0] undoDst,
  input  logic [$clog2(PHYS_REGS)-1:0] undoOld,
  output logic [$clog2(PHYS_REGS)-1:0] srcATag,
  output logic [$clog2(PHYS_REGS)-1:0] srcBTag,
  output logic [$clog2(PHYS_REGS)-1:0] oldTag
);
  localparam int AW = $clog2(ARCH_REGS);
  localparam int PW = $clog2(PHYS_REGS);

  logic [PW-1:0] aliasMap [ARCH_REGS];

  // Reads see the table before this cycle's write.
  always_comb begin
    srcATag = aliasMap[srcA];
    srcBTag = aliasMap[srcB];
    oldTag  = aliasMap[dst];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ARCH_REGS; i++) aliasMap[i] <= PW'(i);
    end else if (strobe.undo) begin
      aliasMap[undoDst] <= undoOld;
    end else if (strobe.alloc) begin
      aliasMap[dst] <= newTag;
    end
  end

  // R5: the destination entry follows the allocated tag
  assert_dst_updated_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.alloc |=> (aliasMap[$past(dst)] == $past(newTag)));
  // R9: an undo restores the recorded mapping
  assert_undo_restores_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.undo |=> (aliasMap[$past(undoDst)] == $past(undoOld)));
  logic [AW-1:0] unusedAw;
  assign unusedAw = '0;
endmodule

// File: rtl/rename_map_unit.sv
module rename_map_unit
  import rename_pkg::*;
#(
  parameter int ARCH_REGS = 8,
  parameter int ROB_DEPTH = 8,
  localparam int PHYS_REGS = 1 << $clog2(ARCH_REGS + ROB_DEPTH),
  localparam int AW = $clog2(ARCH_REGS),
  localparam int PW = $clog2(PHYS_REGS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          renValid,
  input  logic          renHasDst,
  input  logic [AW-1:0] renSrcA,
  input  logic [AW-1:0] renSrcB,
  input  logic [AW-1:0] renDst,
  output logic          renReady,
  output logic [PW-1:0] outSrcATag,
  output logic [PW-1:0] outSrcBTag,
  output logic [PW-1:0] outNewTag,
  output logic [PW-1:0] outOldTag,
  input  logic          cmtValid,
  input  logic [PW-1:0] cmtTag,
  input  logic          undoValid,
  input  logic [AW-1:0] undoDst,
  input  logic [PW-1:0] undoOldTag,
  input  logic [PW-1:0] undoNewTag
);
  rnStrobe_t strobe;
  logic      freeEmpty;

  rename_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .renValid(renValid), .renHasDst(renHasDst),
    .cmtValid(cmtValid), .undoValid(undoValid), .freeEmpty(freeEmpty),
    .renReady(renReady), .strobe(strobe)
  );

  rename_freelist #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) u_free (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmtTag(cmtTag),
    .undoTag(undoNewTag), .headTag(outNewTag), .empty(freeEmpty)
  );

  rename_table #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) u_table (
    .clk(clk), .rstN(rstN), .strobe(strobe), .srcA(renSrcA), .srcB(renSrcB),
    .dst(renDst), .newTag(outNewTag), .undoDst(undoDst), .undoOld(undoOldTag),
    .srcATag(outSrcATag), .srcBTag(outSrcBTag), .oldTag(outOldTag)
  );
endmodule

// File: tb/rename_map_unit_bench.sv
module rename_map_unit_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic renValid = 0, renHasDst = 0, cmtValid = 0, undoValid = 0;
  logic [2:0] renSrcA = 0, renSrcB = 0, renDst = 0, undoDst = 0;
  logic [3:0] cmtTag = 0, undoOldTag = 0, undoNewTag = 0;
  logic renReady;
  logic [3:0] outSrcATag, outSrcBTag, outNewTag, outOldTag;

  int total = 0, bad = 0;
  bit done = 0;
  int expMap [8];
  int expFree [$];

  always #2 clk = ~clk;  // 250 MHz

  rename_map_unit u_rename_map_unit (
    .clk(clk), .rstN(rstN), .renValid(renValid), .renHasDst(renHasDst),
    .renSrcA(renSrcA), .renSrcB(renSrcB), .renDst(renDst), .renReady(renReady),
    .outSrcATag(outSrcATag), .outSrcBTag(outSrcBTag), .outNewTag(outNewTag),
    .outOldTag(outOldTag), .cmtValid(cmtValid), .cmtTag(cmtTag),
    .undoValid(undoValid), .undoDst(undoDst), .undoOldTag(undoOldTag),
    .undoNewTag(undoNewTag)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One cycle: drive at negedge, check mid-low phase, update model at posedge.
  task automatic step(input bit v, input bit hd, input int dst, input int sa, input int sb,
                      input bit cv, input int ct, input bit uv, input int ud, input int uo,
                      input int un, input string req, output int gotNew, output int gotOld);
    bit expReady, took;
    @(negedge clk);
    renValid = v; renHasDst = hd; renDst = 3'(dst); renSrcA = 3'(sa); renSrcB = 3'(sb);
    cmtValid = cv; cmtTag = 4'(ct);
    undoValid = uv; undoDst = 3'(ud); undoOldTag = 4'(uo); undoNewTag = 4'(un);
    #1;
    expReady = !uv && (!hd || expFree.size() > 0);
    check(req, "renReady", int'(renReady), int'(expReady));
    took = v && expReady;
    gotNew = int'(outNewTag); gotOld = int'(outOldTag);
    if (took) begin
      check(req, "srcA tag", int'(outSrcATag), expMap[sa]);
      check(req, "srcB tag", int'(outSrcBTag), expMap[sb]);
      if (hd) begin
        check(req, "new tag", int'(outNewTag), expFree[0]);
        check(req, "old tag", int'(outOldTag), expMap[dst]);
      end
    end
    @(posedge clk);
    if (took && hd) begin
      expMap[dst] = expFree.pop_front();
    end
    if (cv) expFree.push_back(ct);
    if (uv) begin
      expFree.push_back(un);
      expMap[ud] = uo;
    end
    #1;
    renValid = 0; cmtValid = 0; undoValid = 0;
  endtask

  int nt, ot, recDst, recOld, recNew;

  task automatic t_reset;  // R1: identity map, 8 free tags in ascending order
    int n, o;
    for (int i = 0; i < 8; i++) step(1, 0, 0, i, 7 - i, 0, 0, 0, 0, 0, 0, "R1", n, o);
  endtask

  task automatic t_raw;  // R2, R4, R5
    int n, o;
    step(1, 1, 2, 3, 4, 0, 0, 0, 0, 0, 0, "R4", n, o);
    step(1, 1, 5, 2, 2, 0, 0, 0, 0, 0, 0, "R2", n, o);
    step(1, 0, 0, 5, 2, 0, 0, 0, 0, 0, 0, "R5", n, o);
  endtask

  task automatic t_same;  // R3
    int n, o;
    step(1, 1, 1, 1, 1, 0, 0, 0, 0, 0, 0, "R3", n, o);
  endtask

  task automatic t_fill;  // R4 drain, R6 stall, R7 no-dest passes
    int n, o;
    int dl[5] = '{0, 3, 4, 6, 7};
    foreach (dl[k]) step(1, 1, dl[k], k, 7 - k, 0, 0, 0, 0, 0, 0, "R4", n, o);
    step(1, 1, 3, 0, 0, 0, 0, 0, 0, 0, 0, "R6", n, o);
    step(1, 0, 3, 3, 6, 0, 0, 0, 0, 0, 0, "R7", n, o);
  endtask

  task automatic t_cmt_alloc;  // R10, R6 resume, R8
    int n, o;
    step(1, 1, 3, 0, 0, 1, 2, 0, 0, 0, 0, "R10", n, o);
    step(1, 1, 3, 1, 2, 0, 0, 0, 0, 0, 0, "R6", n, o);
    step(0, 0, 0, 0, 0, 1, 1, 0, 0, 0, 0, "R8", n, o);
    step(1, 1, 4, 4, 3, 1, 5, 0, 0, 0, 0, "R10", n, o);
    step(1, 1, 6, 6, 4, 0, 0, 0, 0, 0, 0, "R8", recNew, recOld);
    recDst = 6;
  endtask

  task automatic t_undo;  // R9
    int n, o;
    step(1, 1, 0, 0, 0, 0, 0, 1, recDst, recOld, recNew, "R9", n, o);
    step(1, 0, 0, 6, 6, 0, 0, 0, 0, 0, 0, "R9", n, o);
    step(1, 1, 0, 6, 0, 0, 0, 0, 0, 0, 0, "R9", n, o);
  endtask

  task automatic t_nodst_keeps;  // R7
    int n, o;
    step(1, 0, 0, 2, 5, 1, 3, 0, 0, 0, 0, "R7", n, o);
    step(1, 1, 2, 2, 1, 0, 0, 0, 0, 0, 0, "R7", recNew, recOld);
    recDst = 2;
  endtask

  task automatic t_both;  // R11
    int n, o;
    step(1, 1, 7, 0, 0, 1, 9, 1, recDst, recOld, recNew, "R11", n, o);
    step(1, 1, 7, 2, 7, 0, 0, 0, 0, 0, 0, "R11", n, o);
    step(1, 1, 5, 7, 5, 0, 0, 0, 0, 0, 0, "R11", n, o);
    step(1, 1, 5, 7, 5, 0, 0, 0, 0, 0, 0, "R6", n, o);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) expMap[i] = i;
    for (int i = 8; i < 16; i++) expFree.push_back(i);
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    renValid = 1; renHasDst = 1;
    #1 check("R1", "renReady after reset", int'(renReady), 1);
    renValid = 0; renHasDst = 0;
    t_reset();
    t_raw();
    t_same();
    t_fill();
    t_cmt_alloc();
    t_undo();
    t_nodst_keeps();
    t_both();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule